// File: doc/BRIEF.md
# Synthesizer Serial Programming Register Bank

This block is the configuration front end of a dual frequency synthesizer. A host loads it over a three-wire serial link: a data line, a shift clock and a strobe. While the strobe is low, each rising shift-clock edge moves one data bit into a shift register, most significant bit first. Raising the strobe freezes that register. The word it holds is then classified by its length and by its leading address bits, and written to the register it names.

Two word lengths exist: 24 and 32 bits. Configuration words for the prescaler/phase set (called B here), the control set (C), the setup set (D) and the test set (E) are 24 bits long and carry a 4-bit address. The main-divider word (A) carries a 1-bit address. Its length, 24 or 32 bits, is set by a mode bit held in the D register. B-word fields do not act at once: they wait in a staging register. They reach the working outputs only when an A word is committed.

A commit happens only in a div_clk cycle where the divider's sync input is high while the strobe is still held high. This lets the divider reload without a phase jump. A commit also raises a charge-pump speed-up flag, which stays set until the strobe falls. The serial shift logic runs on the serial clock. Decoding and every register update run on the main-divider clock, behind a two-flop strobe synchronizer.

Top module: `synth_prog_bank`

## Requirements
- R1: While ser_strobe is low, each rising ser_clk edge shifts ser_data into the word, most significant bit first. The first bit after a strobe-low period starts a new word.
- R2: While ser_strobe is high, ser_clk edges change neither the shifted word nor its bit count.
- R3: A word is decoded only if exactly 24 or 32 bits were shifted. A 32-bit word is accepted only as an A word while long mode is set. A 24-bit A word is accepted only while long mode is clear. Every other word is discarded and leaves all outputs unchanged.
- R4: On a 24-bit word the first bit selects the address width. A first bit of 0 marks an A word. A first bit of 1 marks a 4-bit address: 1000 writes the B staging register, 1001 writes cfg_c, 1010 writes cfg_d and 1011 writes cfg_e, each with the low 20 bits. Codes 11xx are discarded.
- R5: A D-word write clears cfg_e to zero. long_mode equals bit 0 of cfg_d.
- R6: B staging layout is nm4 = bits 19:16, cn = bits 15:8, pr = bits 7:0. A B write leaves work_nm4, work_cn and work_pr unchanged until the next A commit.
- R7: An accepted A word is held pending. It commits on the first div_clk edge where div_sync is high and the synchronized strobe is still high. With div_sync low, work outputs stay unchanged. A strobe fall before the commit cancels the pending word.
- R8: On commit, work_main takes the low 23 bits of the A word, and work_nm4 and work_pr take the staged B fields. work_cn takes the staged B cn when the A word was 24 bits, and bits 30:23 of the A word when it was 32 bits.
- R9: speedup rises on the commit edge and stays high while the strobe is high. It returns to 0 within three div_clk edges after ser_strobe falls.
- R10: After reset, all configuration, work outputs and speedup are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ser_clk | input | 1 | Serial shift clock, rising edge active |
| ser_strobe | input | 1 | Low: shift enabled; rising: word decoded |
| ser_data | input | 1 | Serial data bit |
| div_clk | input | 1 | Main-divider clock for decoding and registers |
| div_sync | input | 1 | High when the divider permits an A-word commit |
| cfg_c | output | 20 | C register |
| cfg_d | output | 20 | D register |
| cfg_e | output | 20 | E (test) register |
| long_mode | output | 1 | A-word length select (0: 24-bit, 1: 32-bit) |
| work_main | output | 23 | Working main-divider data |
| work_nm4 | output | 4 | Working nm4 field |
| work_cn | output | 8 | Working cn field |
| work_pr | output | 8 | Working pr field |
| speedup | output | 1 | Charge-pump speed-up flag |

## Verification
The bench sweeps every shift length from 20 to 34 bits with one fixed pattern. Only the exact 24-bit case may land, so this separates a correct length gate from one that accepts nearby lengths or masks the count. It then sweeps all sixteen 4-bit address codes, which tells a correct destination decode apart from a swapped or partial one, and shows that A words with no sync never reach the working registers. A-word cases run with the sync held low, with the strobe dropped before the sync, and in both length modes. These separate the staged CN path from the direct one, and a gated commit from an eager one. The speed-up flag is checked both at the commit and after the strobe falls.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

   typedef enum logic [2:0] {
      K_NONE = 3'd0,
      K_A    = 3'd1,
      K_B    = 3'd2,
      K_C    = 3'd3,
      K_D    = 3'd4,
      K_E    = 3'd5
   } word_kind_t;

   localparam logic [3:0] CODE_B = 4'b1000;
   localparam logic [3:0] CODE_C = 4'b1001;
   localparam logic [3:0] CODE_D = 4'b1010;
   localparam logic [3:0] CODE_E = 4'b1011;

endpackage

// File: rtl/sp_shift_in.sv
module sp_shift_in #(
   parameter int MAX_LEN = 32,
   parameter int CNT_W   = $clog2(MAX_LEN + 2)
) (
   input  logic               rst_n,
   input  logic               ser_clk,
   input  logic               ser_strobe,
   input  logic               ser_data,
   output logic [MAX_LEN-1:0] sh_word,
   output logic [CNT_W-1:0]   bit_cnt
);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_LEN + 1);

   logic fresh;

   // a strobe-high period arms a restart of the word on the next shift
   always_ff @(posedge ser_clk or negedge rst_n or posedge ser_strobe) begin
      if (!rst_n)          fresh <= 1'b1;
      else if (ser_strobe) fresh <= 1'b1;
      else                 fresh <= 1'b0;
   end

   always_ff @(posedge ser_clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_word <= '0;
         bit_cnt <= '0;
      end else if (!ser_strobe) begin
         if (fresh) begin
            sh_word <= {{(MAX_LEN-1){1'b0}}, ser_data};
            bit_cnt <= CNT_W'(1);
         end else begin
            sh_word <= {sh_word[MAX_LEN-2:0], ser_data};
            if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sp_sync.sv
module sp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] stg;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[0] <= 1'b0;
               else        stg[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[i] <= 1'b0;
               else        stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sp_word_decode.sv
module sp_word_decode
   import synth_prog_pkg::*;
#(
   parameter int SHORT_LEN = 24,
   parameter int LONG_LEN  = 32,
   parameter int ADDR_W    = 4,
   parameter int CNT_W     = $clog2(LONG_LEN + 2),
   parameter int PAY_W     = SHORT_LEN - ADDR_W,
   parameter int A1_W      = LONG_LEN - 1
) (
   input  logic [LONG_LEN-1:0] sh_word,
   input  logic [CNT_W-1:0]    bit_cnt,
   input  logic                long_mode,
   output word_kind_t          kind,
   output logic [PAY_W-1:0]    cfg_pay,
   output logic [A1_W-1:0]     a_pay
);
   localparam int A0_W = SHORT_LEN - 1;

   logic              is_short, is_long;
   logic [ADDR_W-1:0] code;

   assign is_short = (bit_cnt == CNT_W'(SHORT_LEN));
   assign is_long  = (bit_cnt == CNT_W'(LONG_LEN));
   assign code     = sh_word[SHORT_LEN-1 -: ADDR_W];
   assign cfg_pay  = sh_word[PAY_W-1:0];

   always_comb begin
      kind  = K_NONE;
      a_pay = '0;
      if (is_short && !sh_word[SHORT_LEN-1]) begin
         if (!long_mode) begin
            kind  = K_A;
            a_pay = A1_W'(sh_word[A0_W-1:0]);
         end
      end else if (is_long && !sh_word[LONG_LEN-1]) begin
         if (long_mode) begin
            kind  = K_A;
            a_pay = sh_word[A1_W-1:0];
         end
      end else if (is_short) begin
         unique case (code)
            CODE_B:  kind = K_B;
            CODE_C:  kind = K_C;
            CODE_D:  kind = K_D;
            CODE_E:  kind = K_E;
            default: kind = K_NONE;
         endcase
      end
   end
endmodule

// File: rtl/synth_prog_bank.sv
module synth_prog_bank
   import synth_prog_pkg::*;
#(
   parameter int SHORT_LEN   = 24,
   parameter int LONG_LEN    = 32,
   parameter int ADDR_W      = 4,
   parameter int NM4_W       = 4,
   parameter int CN_W        = 8,
   parameter int PR_W        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        rst_n,
   input  logic                        ser_clk,
   input  logic                        ser_strobe,
   input  logic                        ser_data,
   input  logic                        div_clk,
   input  logic                        div_sync,
   output logic [SHORT_LEN-ADDR_W-1:0] cfg_c,
   output logic [SHORT_LEN-ADDR_W-1:0] cfg_d,
   output logic [SHORT_LEN-ADDR_W-1:0] cfg_e,
   output logic                        long_mode,
   output logic [SHORT_LEN-2:0]        work_main,
   output logic [NM4_W-1:0]            work_nm4,
   output logic [CN_W-1:0]             work_cn,
   output logic [PR_W-1:0]             work_pr,
   output logic                        speedup
);
   localparam int PAY_W  = SHORT_LEN - ADDR_W;
   localparam int MAIN_W = SHORT_LEN - 1;
   localparam int A1_W   = LONG_LEN - 1;
   localparam int CNT_W  = $clog2(LONG_LEN + 2);

   initial begin
      if (NM4_W + CN_W + PR_W != PAY_W)
         $fatal(1, "staged field widths must fill the short payload");
      if (A1_W - MAIN_W != CN_W)
         $fatal(1, "long A word must carry exactly one cn field");
      if (LONG_LEN <= SHORT_LEN || SYNC_STAGES < 2)
         $fatal(1, "bad length or synchronizer depth");
   end

   logic [LONG_LEN-1:0] sh_word;
   logic [CNT_W-1:0]    bit_cnt;
   logic                stb_s, stb_q, stb_rise;
   word_kind_t          kind;
   logic [PAY_W-1:0]    cfg_pay;
   logic [A1_W-1:0]     a_pay;

   logic [PAY_W-1:0]  b_stage;
   logic [MAIN_W-1:0] hold_main;
   logic [CN_W-1:0]   hold_cn;
   logic              hold_direct, pend;

   sp_shift_in #(.MAX_LEN(LONG_LEN), .CNT_W(CNT_W)) u_shift (
      .rst_n(rst_n), .ser_clk(ser_clk), .ser_strobe(ser_strobe),
      .ser_data(ser_data), .sh_word(sh_word), .bit_cnt(bit_cnt));

   sp_sync #(.STAGES(SYNC_STAGES)) u_stb_sync (
      .clk(div_clk), .rst_n(rst_n), .d(ser_strobe), .q(stb_s));

   sp_word_decode #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .ADDR_W(ADDR_W),
                    .CNT_W(CNT_W), .PAY_W(PAY_W), .A1_W(A1_W)) u_dec (
      .sh_word(sh_word), .bit_cnt(bit_cnt), .long_mode(long_mode),
      .kind(kind), .cfg_pay(cfg_pay), .a_pay(a_pay));

   assign stb_rise  = stb_s & ~stb_q;
   assign long_mode = cfg_d[0];

   always_ff @(posedge div_clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_q       <= 1'b0;
         cfg_c       <= '0;
         cfg_d       <= '0;
         cfg_e       <= '0;
         b_stage     <= '0;
         hold_main   <= '0;
         hold_cn     <= '0;
         hold_direct <= 1'b0;
         pend        <= 1'b0;
         work_main   <= '0;
         work_nm4    <= '0;
         work_cn     <= '0;
         work_pr     <= '0;
         speedup     <= 1'b0;
      end else begin
         stb_q <= stb_s;
         if (stb_rise) begin
            unique case (kind)
               K_B: b_stage <= cfg_pay;
               K_C: cfg_c   <= cfg_pay;
               K_D: begin
                  cfg_d <= cfg_pay;
                  cfg_e <= '0;
               end
               K_E: cfg_e <= cfg_pay;
               K_A: begin
                  hold_main   <= a_pay[MAIN_W-1:0];
                  hold_cn     <= a_pay[A1_W-1:MAIN_W];
                  hold_direct <= long_mode;
                  pend        <= 1'b1;
               end
               default: ;
            endcase
         end
         if (!stb_s) begin
            pend    <= 1'b0;
            speedup <= 1'b0;
         end else if (pend && div_sync) begin
            work_main <= hold_main;
            work_nm4  <= b_stage[PAY_W-1 -: NM4_W];
            work_pr   <= b_stage[PR_W-1:0];
            work_cn   <= hold_direct ? hold_cn : b_stage[PR_W +: CN_W];
            pend      <= 1'b0;
            speedup   <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sp_prog_checker.sv
module sp_prog_checker #(
   parameter int MAIN_W = 23,
   parameter int PAY_W  = 20,
   parameter int SH_W   = 32
) (
   input logic              rst_n,
   input logic              div_clk,
   input logic              ser_clk,
   input logic              ser_strobe,
   input logic              div_sync,
   input logic              speedup,
   input logic [MAIN_W-1:0] work_main,
   input logic [PAY_W-1:0]  cfg_d,
   input logic [PAY_W-1:0]  cfg_e,
   input logic [SH_W-1:0]   sh_word
);
   p_frozen_r2: assert property (@(posedge ser_clk) disable iff (!rst_n)
      ser_strobe |=> $stable(sh_word));

   p_e_clear_r5: assert property (@(posedge div_clk) disable iff (!rst_n)
      !$stable(cfg_d) |-> (cfg_e == '0));

   p_main_hold_r7: assert property (@(posedge div_clk) disable iff (!rst_n)
      !$past(div_sync) |-> $stable(work_main));

   p_spd_cause_r9: assert property (@(posedge div_clk) disable iff (!rst_n)
      $rose(speedup) |-> $past(div_sync));

   p_spd_clear_r9: assert property (@(posedge div_clk) disable iff (!rst_n)
      (!ser_strobe && !$past(ser_strobe) && !$past(ser_strobe, 2) && !$past(ser_strobe, 3))
      |-> !speedup);
endmodule

bind synth_prog_bank sp_prog_checker #(
   .MAIN_W(MAIN_W), .PAY_W(PAY_W), .SH_W(LONG_LEN)
) u_prog_chk (
   .rst_n(rst_n), .div_clk(div_clk), .ser_clk(ser_clk), .ser_strobe(ser_strobe),
   .div_sync(div_sync), .speedup(speedup), .work_main(work_main),
   .cfg_d(cfg_d), .cfg_e(cfg_e), .sh_word(sh_word));

// File: tb/synth_prog_bank_tb_top.sv
module synth_prog_bank_tb_top;
   logic rst_n = 1'b0, ser_clk = 1'b0, ser_strobe = 1'b1, ser_data = 1'b0;
   logic div_clk = 1'b0, div_sync = 1'b0;
   logic [19:0] cfg_c, cfg_d, cfg_e;
   logic        long_mode, speedup;
   logic [22:0] work_main;
   logic [3:0]  work_nm4;
   logic [7:0]  work_cn, work_pr;

   always #10 div_clk = ~div_clk;

   synth_prog_bank dut_i (
      .rst_n(rst_n), .ser_clk(ser_clk), .ser_strobe(ser_strobe), .ser_data(ser_data),
      .div_clk(div_clk), .div_sync(div_sync), .cfg_c(cfg_c), .cfg_d(cfg_d),
      .cfg_e(cfg_e), .long_mode(long_mode), .work_main(work_main),
      .work_nm4(work_nm4), .work_cn(work_cn), .work_pr(work_pr), .speedup(speedup));

   int total = 0, bad = 0;
   logic [19:0] m_c = '0, m_d = '0, m_e = '0, m_bt = '0;
   logic [22:0] m_main = '0, h_main = '0;
   logic [3:0]  m_nm4 = '0;
   logic [7:0]  m_cn = '0, m_pr = '0, h_cn = '0;
   logic        m_spd = 1'b0, m_pend = 1'b0, h_dir = 1'b0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic chk_all(string tag);
      chk({tag, " cfg_c"}, 32'(cfg_c), 32'(m_c));
      chk({tag, " cfg_d"}, 32'(cfg_d), 32'(m_d));
      chk({tag, " cfg_e"}, 32'(cfg_e), 32'(m_e));
      chk({tag, " long"}, 32'(long_mode), 32'(m_d[0]));
      chk({tag, " main"}, 32'(work_main), 32'(m_main));
      chk({tag, " nm4"}, 32'(work_nm4), 32'(m_nm4));
      chk({tag, " cn"}, 32'(work_cn), 32'(m_cn));
      chk({tag, " pr"}, 32'(work_pr), 32'(m_pr));
      chk({tag, " speedup"}, 32'(speedup), 32'(m_spd));
   endtask

   task automatic model_word(logic [31:0] w, int len);
      if (len == 24 && w[23]) begin
         case (w[23:20])
            4'b1000: m_bt = w[19:0];
            4'b1001: m_c  = w[19:0];
            4'b1010: begin m_d = w[19:0]; m_e = '0; end
            4'b1011: m_e  = w[19:0];
            default: ;
         endcase
      end else if (len == 24 && !m_d[0]) begin
         h_main = w[22:0]; h_dir = 1'b0; m_pend = 1'b1;
      end else if (len == 32 && !w[31] && m_d[0]) begin
         h_main = w[22:0]; h_cn = w[30:23]; h_dir = 1'b1; m_pend = 1'b1;
      end
   endtask

   task automatic settle();
      repeat (6) @(posedge div_clk);
      #5;
   endtask

   task automatic shift_bits(logic [31:0] w, int len);
      ser_strobe = 1'b0;
      m_pend = 1'b0;
      m_spd  = 1'b0;
      #5;
      for (int i = len - 1; i >= 0; i--) begin
         ser_data = w[i];
         #5 ser_clk = 1'b1;
         #5 ser_clk = 1'b0;
      end
      #3 ser_strobe = 1'b1;
   endtask

   task automatic send(logic [31:0] w, int len);
      shift_bits(w, len);
      settle();
      model_word(w, len);
   endtask

   task automatic drop_strobe();
      ser_strobe = 1'b0;
      m_pend = 1'b0;
      m_spd  = 1'b0;
      repeat (4) @(posedge div_clk);
      #5;
   endtask

   task automatic pulse_sync();
      @(negedge div_clk) div_sync = 1'b1;
      @(negedge div_clk) div_sync = 1'b0;
      if (m_pend && ser_strobe) begin
         m_main = h_main;
         m_nm4  = m_bt[19:16];
         m_pr   = m_bt[7:0];
         m_cn   = h_dir ? h_cn : m_bt[15:8];
         m_pend = 1'b0;
         m_spd  = 1'b1;
      end
      #2;
   endtask

   initial begin
      #1000000;
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge div_clk);
      #5 rst_n = 1'b1;
      settle();
      chk_all("R10 reset");

      // R3: only exact lengths land
      for (int len = 20; len <= 34; len++) begin
         if (len != 24) begin
            send({8'h00, 4'b1001, 20'h5A5A5}, len);
            chk_all($sformatf("R3 len%0d", len));
         end
      end

      // R4, R1: every address code, distinct payloads
      for (int code = 0; code < 16; code++) begin
         send({8'h00, 4'(code), 20'h10000 + 20'(code * 'h111)}, 24);
         chk_all($sformatf("R4 code%0d", code));
      end
      chk("R4 e kept", 32'(cfg_e), 32'h10BBB);

      send({8'h00, 4'b1010, 20'h00002}, 24);
      chk_all("R5 d clears e");
      chk("R5 e zero", 32'(cfg_e), 32'h0);

      // R6/R7/R8 in short mode
      send({8'h00, 4'b1000, 4'h7, 8'h3C, 8'hE1}, 24);
      chk_all("R6 staged only");
      send({8'h00, 1'b0, 23'h12345}, 24);
      repeat (20) @(posedge div_clk);
      #5;
      chk_all("R7 no sync");
      pulse_sync();
      chk_all("R8 cn staged");
      chk("R9 speedup set", 32'(speedup), 32'h1);
      repeat (10) @(posedge div_clk);
      #5;
      chk("R9 speedup held", 32'(speedup), 32'h1);
      drop_strobe();
      chk_all("R9 speedup cleared");

      // R7 cancel on strobe fall
      #3 ser_strobe = 1'b1;
      settle();
      send({8'h00, 1'b0, 23'h7FFFF}, 24);
      drop_strobe();
      pulse_sync();
      chk_all("R7 cancel");
      #3 ser_strobe = 1'b1;
      settle();

      // R2: clocks while strobe high are ignored
      shift_bits({8'h00, 4'b1001, 20'hC3A51}, 24);
      ser_data = 1'b1;
      for (int k = 0; k < 5; k++) begin
         #1 ser_clk = 1'b1;
         #1 ser_clk = 1'b0;
      end
      settle();
      model_word({8'h00, 4'b1001, 20'hC3A51}, 24);
      chk_all("R2 frozen");

      // long mode
      send({8'h00, 4'b1010, 20'h00001}, 24);
      chk_all("R5 long on");
      send({8'h00, 1'b0, 23'h0BEEF}, 24);
      pulse_sync();
      chk_all("R3 short A in long mode");
      send({8'h00, 4'b1000, 4'h2, 8'h99, 8'h11}, 24);
      send({1'b0, 8'hC7, 23'h54321}, 32);
      chk_all("R6 staged before A1");
      pulse_sync();
      chk_all("R8 cn direct");
      send({8'h00, 4'b1000, 4'hF, 8'h0F, 8'hF0}, 24);
      chk_all("R6 after commit");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule